// File: doc/BRIEF.md
# Indexed Displacement Load/Store Executor

This block runs a small slice of an 8-bit processor's data-movement instructions against a byte-wide memory with a 16-bit address space. It reads each instruction one byte at a time through a single synchronous memory port. It decodes an optional base-select prefix and the opcode, forms the effective address, and then carries out a single memory access or a register-file write. When the instruction retires, the program counter moves past the instruction and a one-cycle done strobe is raised.

The supported work falls into four groups:

- byte transfers between a general register and memory at an index register plus a signed displacement;
- an immediate byte stored at such an indexed address;
- accumulator transfers at an absolute address;
- 16-bit immediate loads into the register pairs, the stack pointer and the two index registers.

Any other encoding stops the block with an illegal-instruction flag set. In that case nothing architectural is touched.

Memory timing is one cycle of read latency. A read requested with `mem_rd_o` in one cycle returns its byte on `mem_rdata_i` in the next cycle. A write happens at the clock edge that ends the cycle in which `mem_wr_o` is high. The whole architectural state is visible on output ports.

Top module: `idx_ldst_exec`

## Requirements
- R1: While reset is held and right after it, the program counter and every register (A, BC, DE, HL, IX, IY, SP) read zero, and done and illegal are low.
- R2: A first byte of 0xFD selects IY as the base of an indexed access, and a first byte of 0xDD selects IX.
- R3: With a prefix, second byte 0x70 | r stores register r to the indexed address. The 3-bit code r is 0 = B, 1 = C, 2 = D, 3 = E, 4 = H, 5 = L, 7 = A.
- R4: With a prefix, second byte 0x46 | (r << 3) loads register r from the indexed address, with r coded as in R3.
- R5: The third byte is a two's-complement displacement. The address is the index register plus the sign-extended displacement, taken modulo 65536, so it may wrap in either direction.
- R6: Prefix followed by 0x36 takes a displacement byte and then a data byte. It writes the data byte to the indexed address, and the program counter advances by 4.
- R7: Opcode 0x3A loads A from the absolute address formed by the next two bytes, low byte first. Opcode 0x32 stores A there. Both advance the program counter by 3.
- R8: Opcodes 0x01, 0x11, 0x21 and 0x31 load BC, DE, HL and SP with a 16-bit immediate, low byte first. In a pair, the first-named register receives the high byte. Prefix followed by 0x21 loads IX (0xDD) or IY (0xFD) and advances the program counter by 4; the others advance it by 3.
- R9: An indexed register load or store advances the program counter by 3. The program counter changes only in the single cycle in which done is high, and done is a one-cycle pulse per retired instruction.
- R10: An unsupported encoding raises illegal, and illegal stays high until reset. After it, no register, the program counter and memory change, and done stays low.
- R11: Reads and writes never occur in the same cycle, and a memory write lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rd_o | output | 1 | Read request; data is returned on the next cycle |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| done_o | output | 1 | One-cycle strobe when an instruction retires |
| illegal_o | output | 1 | Sticky unsupported-instruction flag |
| pc_o | output | 16 | Program counter |
| a_o | output | 8 | Accumulator |
| bc_o | output | 16 | B (high) and C (low) |
| de_o | output | 16 | D (high) and E (low) |
| hl_o | output | 16 | H (high) and L (low) |
| ix_o | output | 16 | Index register X |
| iy_o | output | 16 | Index register Y |
| sp_o | output | 16 | Stack pointer |

## Verification
The properties assume that the memory answers every read with a byte on the following cycle. They also assume that reset is the only way out of the halted state. The stimulus keeps to both assumptions: the bench memory model always registers the addressed byte one cycle after a read, and reset is released once and never raised again. The program places its code, data and every indexed or absolute target in disjoint address ranges, so no write ever lands on an instruction that has yet to be fetched. It ends with a single unsupported encoding, so the halted state is entered exactly once.

// File: rtl/idx_ldst_pkg.sv
package idx_ldst_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_ST_IDX, K_LD_IDX, K_ST_IMM, K_LD_ABS, K_ST_ABS, K_LD16
  } kind_e;

  // pair codes 0..3 follow opcode bits [5:4] of the unprefixed 16-bit loads
  typedef enum logic [2:0] {
    P_BC = 3'd0, P_DE = 3'd1, P_HL = 3'd2, P_SP = 3'd3, P_IX = 3'd4, P_IY = 3'd5
  } pair_e;

  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_EXEC, S_WB, S_HALT
  } state_e;

  typedef struct packed {
    kind_e      kind;
    pair_e      pair;
    logic [2:0] reg_idx;
    logic [2:0] len;
    logic       use_iy;
    logic       pfx;
    logic       illegal;
  } dec_t;

  localparam logic [7:0] PFX_X       = 8'hDD;
  localparam logic [7:0] PFX_Y       = 8'hFD;
  localparam logic [7:0] OP_ST_IMM   = 8'h36;
  localparam logic [7:0] OP_LD16_HL  = 8'h21;
  localparam logic [7:0] OP_LD_A_ABS = 8'h3A;
  localparam logic [7:0] OP_ST_A_ABS = 8'h32;
  localparam logic [2:0] R_MEM       = 3'd6;
  localparam logic [2:0] R_A         = 3'd7;

endpackage

// File: rtl/idx_ldst_dec.sv
module idx_ldst_dec
  import idx_ldst_pkg::*;
(
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  input  logic       have_b1_i,
  output dec_t       dec_o
);

  dec_t d;

  always_comb begin
    d         = '0;
    d.kind    = K_NONE;
    d.pair    = P_BC;
    d.len     = 3'd1;
    d.pfx     = (b0_i == PFX_X) || (b0_i == PFX_Y);
    d.use_iy  = (b0_i == PFX_Y);
    if (d.pfx) begin
      // length unknown until the second byte is in
      d.len = 3'd2;
      if (have_b1_i) begin
        if (b1_i == OP_ST_IMM) begin
          d.kind = K_ST_IMM;
          d.len  = 3'd4;
        end else if (b1_i == OP_LD16_HL) begin
          d.kind = K_LD16;
          d.len  = 3'd4;
          d.pair = d.use_iy ? P_IY : P_IX;
        end else if (b1_i[7:3] == 5'b01110 && b1_i[2:0] != R_MEM) begin
          d.kind    = K_ST_IDX;
          d.len     = 3'd3;
          d.reg_idx = b1_i[2:0];
        end else if (b1_i[7:6] == 2'b01 && b1_i[2:0] == R_MEM && b1_i[5:3] != R_MEM) begin
          d.kind    = K_LD_IDX;
          d.len     = 3'd3;
          d.reg_idx = b1_i[5:3];
        end else begin
          d.illegal = 1'b1;
        end
      end
    end else if (b0_i == OP_LD_A_ABS) begin
      d.kind    = K_LD_ABS;
      d.len     = 3'd3;
      d.reg_idx = R_A;
    end else if (b0_i == OP_ST_A_ABS) begin
      d.kind    = K_ST_ABS;
      d.len     = 3'd3;
      d.reg_idx = R_A;
    end else if (b0_i[7:6] == 2'b00 && b0_i[3:0] == 4'h1) begin
      d.kind = K_LD16;
      d.len  = 3'd3;
      d.pair = pair_e'({1'b0, b0_i[5:4]});
    end else begin
      d.illegal = 1'b1;
    end
  end

  assign dec_o = d;

endmodule

// File: rtl/idx_ldst_agu.sv
module idx_ldst_agu #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] ea_o
);

  localparam int EXT_W = AW - DW;

  // carry out of the top bit is dropped: modulo 2^AW
  assign ea_o = base_i + {{EXT_W{disp_i[DW-1]}}, disp_i};

endmodule

// File: rtl/idx_ldst_rf.sv
module idx_ldst_rf
  import idx_ldst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr8_en_i,
  input  logic [2:0]      wr8_idx_i,
  input  logic [DW-1:0]   wr8_data_i,
  input  logic            wr16_en_i,
  input  pair_e           wr16_pair_i,
  input  logic [2*DW-1:0] wr16_data_i,
  input  logic [2:0]      rd8_idx_i,
  output logic [DW-1:0]   rd8_data_o,
  output logic [DW-1:0]   a_o,
  output logic [2*DW-1:0] bc_o,
  output logic [2*DW-1:0] de_o,
  output logic [2*DW-1:0] hl_o,
  output logic [2*DW-1:0] ix_o,
  output logic [2*DW-1:0] iy_o,
  output logic [2*DW-1:0] sp_o
);

  localparam int NR = 8;
  localparam int PW = 2 * DW;

  logic [DW-1:0] r8 [NR];

  for (genvar gi = 0; gi < NR; gi++) begin : g_r8
    if (gi == 6) begin : g_hole
      assign r8[gi] = '0;
    end else begin : g_reg
      localparam bit         IN_PAIR = (gi < 6);
      localparam bit         IS_HI   = ((gi % 2) == 0);
      localparam logic [2:0] MY_PAIR = 3'(gi / 2);
      logic [DW-1:0] q;
      logic          hit16;
      assign hit16 = IN_PAIR && wr16_en_i && (wr16_pair_i == pair_e'(MY_PAIR));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (wr8_en_i && wr8_idx_i == 3'(gi)) begin
          q <= wr8_data_i;
        end else if (hit16) begin
          q <= IS_HI ? wr16_data_i[PW-1:DW] : wr16_data_i[DW-1:0];
        end
      end
      assign r8[gi] = q;
    end
  end

  logic [PW-1:0] ix_q, iy_q, sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ix_q <= '0;
      iy_q <= '0;
      sp_q <= '0;
    end else if (wr16_en_i) begin
      if (wr16_pair_i == P_IX) ix_q <= wr16_data_i;
      if (wr16_pair_i == P_IY) iy_q <= wr16_data_i;
      if (wr16_pair_i == P_SP) sp_q <= wr16_data_i;
    end
  end

  assign rd8_data_o = r8[rd8_idx_i];
  assign a_o        = r8[7];
  assign bc_o       = {r8[0], r8[1]};
  assign de_o       = {r8[2], r8[3]};
  assign hl_o       = {r8[4], r8[5]};
  assign ix_o       = ix_q;
  assign iy_o       = iy_q;
  assign sp_o       = sp_q;

endmodule

// File: rtl/idx_ldst_exec.sv
module idx_ldst_exec
  import idx_ldst_pkg::*;
#(
  parameter int DW = 8,
  parameter int NB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [2*DW-1:0]   mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [2*DW-1:0]   pc_o,
  output logic [DW-1:0]     a_o,
  output logic [2*DW-1:0]   bc_o,
  output logic [2*DW-1:0]   de_o,
  output logic [2*DW-1:0]   hl_o,
  output logic [2*DW-1:0]   ix_o,
  output logic [2*DW-1:0]   iy_o,
  output logic [2*DW-1:0]   sp_o
);

  localparam int AW = 2 * DW;
  localparam int IW = $clog2(NB);

  state_e        st_q, st_d;
  logic [DW-1:0] byte_q [NB];
  logic [DW-1:0] byte_m [NB];
  logic [IW-1:0] idx_q;
  logic [AW-1:0] pc_q;
  logic          done_q, ill_q;
  logic          finish;
  logic [2:0]    nb;
  logic          have_b1;
  dec_t          dec;

  logic          wr8_en, wr16_en;
  logic [DW-1:0] rd8_data;
  logic [AW-1:0] ea, base, abs_addr, imm16;

  // byte being latched is visible to the decoder in the same cycle
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      byte_m[i] = (st_q == S_LATCH && idx_q == IW'(i)) ? mem_rdata_i : byte_q[i];
    end
  end

  assign have_b1 = (st_q != S_LATCH) || (idx_q != '0);
  assign nb      = 3'(idx_q) + 3'd1;

  idx_ldst_dec u_dec (
    .b0_i      (byte_m[0]),
    .b1_i      (byte_m[1]),
    .have_b1_i (have_b1),
    .dec_o     (dec)
  );

  assign base     = dec.use_iy ? iy_o : ix_o;
  assign abs_addr = {byte_q[2], byte_q[1]};
  assign imm16    = dec.pfx ? {byte_q[3], byte_q[2]} : {byte_q[2], byte_q[1]};

  idx_ldst_agu #(.DW(DW), .AW(AW)) u_agu (
    .base_i (base),
    .disp_i (byte_q[2]),
    .ea_o   (ea)
  );

  idx_ldst_rf #(.DW(DW)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr8_en_i    (wr8_en),
    .wr8_idx_i   (dec.reg_idx),
    .wr8_data_i  (mem_rdata_i),
    .wr16_en_i   (wr16_en),
    .wr16_pair_i (dec.pair),
    .wr16_data_i (imm16),
    .rd8_idx_i   (dec.reg_idx),
    .rd8_data_o  (rd8_data),
    .a_o         (a_o),
    .bc_o        (bc_o),
    .de_o        (de_o),
    .hl_o        (hl_o),
    .ix_o        (ix_o),
    .iy_o        (iy_o),
    .sp_o        (sp_o)
  );

  always_comb begin
    st_d        = st_q;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = pc_q + AW'(idx_q);
    mem_wdata_o = rd8_data;
    wr8_en      = 1'b0;
    wr16_en     = 1'b0;
    finish      = 1'b0;
    unique case (st_q)
      S_FETCH: begin
        mem_rd_o = 1'b1;
        st_d     = S_LATCH;
      end
      S_LATCH: begin
        if (dec.illegal)      st_d = S_HALT;
        else if (nb < dec.len) st_d = S_FETCH;
        else                  st_d = S_EXEC;
      end
      S_EXEC: begin
        mem_addr_o = (dec.kind == K_LD_ABS || dec.kind == K_ST_ABS) ? abs_addr : ea;
        unique case (dec.kind)
          K_ST_IDX, K_ST_ABS: begin
            mem_wr_o = 1'b1;
            finish   = 1'b1;
          end
          K_ST_IMM: begin
            mem_wr_o    = 1'b1;
            mem_wdata_o = byte_q[3];
            finish      = 1'b1;
          end
          K_LD_IDX, K_LD_ABS: begin
            mem_rd_o = 1'b1;
            st_d     = S_WB;
          end
          K_LD16: begin
            wr16_en = 1'b1;
            finish  = 1'b1;
          end
          default: st_d = S_HALT;
        endcase
      end
      S_WB: begin
        wr8_en = 1'b1;
        finish = 1'b1;
      end
      default: st_d = S_HALT;
    endcase
    if (finish) st_d = S_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_FETCH;
      idx_q  <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      for (int i = 0; i < NB; i++) byte_q[i] <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (st_q == S_LATCH) begin
        byte_q[idx_q] <= mem_rdata_i;
        if (dec.illegal) ill_q <= 1'b1;
        if (st_d == S_FETCH) idx_q <= idx_q + 1'b1;
      end
      if (finish) begin
        pc_q  <= pc_q + AW'(dec.len);
        idx_q <= '0;
      end
    end
  end

  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign pc_o      = pc_q;

endmodule

// File: rtl/idx_ldst_chk.sv
module idx_ldst_chk #(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic [2*DW-1:0] pc_o,
  input logic [DW-1:0]   a_o,
  input logic [2*DW-1:0] bc_o,
  input logic [2*DW-1:0] de_o,
  input logic [2*DW-1:0] hl_o,
  input logic [2*DW-1:0] ix_o,
  input logic [2*DW-1:0] iy_o,
  input logic [2*DW-1:0] sp_o
);

  assert_no_rd_wr_clash_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_write_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_pc_moves_only_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pc_o));

  assert_illegal_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o && !done_o && !mem_wr_o);

  assert_illegal_freezes_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(pc_o) && $stable(a_o) && $stable(bc_o) && $stable(de_o)
                  && $stable(hl_o) && $stable(ix_o) && $stable(iy_o) && $stable(sp_o));

endmodule

bind idx_ldst_exec idx_ldst_chk #(.DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .pc_o      (pc_o),
  .a_o       (a_o),
  .bc_o      (bc_o),
  .de_o      (de_o),
  .hl_o      (hl_o),
  .ix_o      (ix_o),
  .iy_o      (iy_o),
  .sp_o      (sp_o)
);

// File: tb/idx_ldst_exec_tb_top.sv
`timescale 1ns/1ps
module idx_ldst_exec_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = 8'h00;
  logic        done_o, illegal_o;
  logic [15:0] pc_o, bc_o, de_o, hl_o, ix_o, iy_o, sp_o;
  logic [7:0]  a_o;

  always #2.5 clk_i = ~clk_i;

  idx_ldst_exec dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .illegal_o(illegal_o), .pc_o(pc_o), .a_o(a_o),
    .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .ix_o(ix_o), .iy_o(iy_o), .sp_o(sp_o)
  );

  // sparse memory model, one cycle read latency
  logic [7:0] mem [logic [15:0]];

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem_rd(mem_addr_o);
    if (mem_wr_o) mem[mem_addr_o] = mem_wdata_o;
  end

  typedef struct {
    string       req;
    logic [15:0] pc;
    logic [103:0] st;
    bit          mchk;
    logic [15:0] maddr;
    logic [7:0]  mval;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_pc = 0, m_bc = 0, m_de = 0, m_hl = 0, m_ix = 0, m_iy = 0, m_sp = 0;
  logic [7:0]  m_a = 0;
  logic [15:0] wp = 0;

  task automatic check(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [103:0] model_st();
    return {m_a, m_bc, m_de, m_hl, m_ix, m_iy, m_sp};
  endfunction

  function automatic logic [103:0] dut_st();
    return {a_o, bc_o, de_o, hl_o, ix_o, iy_o, sp_o};
  endfunction

  function automatic logic [7:0] get_r(input int r);
    case (r)
      0: return m_bc[15:8];
      1: return m_bc[7:0];
      2: return m_de[15:8];
      3: return m_de[7:0];
      4: return m_hl[15:8];
      5: return m_hl[7:0];
      default: return m_a;
    endcase
  endfunction

  task automatic set_r(input int r, input logic [7:0] v);
    case (r)
      0: m_bc[15:8] = v;
      1: m_bc[7:0]  = v;
      2: m_de[15:8] = v;
      3: m_de[7:0]  = v;
      4: m_hl[15:8] = v;
      5: m_hl[7:0]  = v;
      default: m_a = v;
    endcase
  endtask

  task automatic emit(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic push(input string req, input bit mchk, input logic [15:0] maddr,
                      input logic [7:0] mval);
    exp_t e;
    e.req = req; e.pc = m_pc; e.st = model_st();
    e.mchk = mchk; e.maddr = maddr; e.mval = mval;
    exp_q.push_back(e);
  endtask

  function automatic logic [15:0] sext(input logic [7:0] d);
    return {{8{d[7]}}, d};
  endfunction

  // monitor: one expected item per retired instruction
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected done", 128'(done_o), 128'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R9", "pc after retire", 128'(pc_o), 128'(e.pc));
        check(e.req, "register state", 128'(dut_st()), 128'(e.st));
        if (e.mchk) check(e.req, "memory byte", 128'(mem_rd(e.maddr)), 128'(e.mval));
      end
    end
  end

  // driver: builds the program and pushes expectations
  task automatic build_program(output logic [15:0] ill_pc);
    // R8: 16-bit immediates
    emit(8'hDD); emit(8'h21); emit(8'h00); emit(8'h10);
    m_ix = 16'h1000; m_pc += 4; push("R8", 0, 0, 0);
    emit(8'hFD); emit(8'h21); emit(8'h10); emit(8'h00);
    m_iy = 16'h0010; m_pc += 4; push("R8", 0, 0, 0);
    emit(8'h01); emit(8'h34); emit(8'h12);
    m_bc = 16'h1234; m_pc += 3; push("R8", 0, 0, 0);
    emit(8'h11); emit(8'h78); emit(8'h56);
    m_de = 16'h5678; m_pc += 3; push("R8", 0, 0, 0);
    emit(8'h21); emit(8'hBC); emit(8'h9A);
    m_hl = 16'h9ABC; m_pc += 3; push("R8", 0, 0, 0);
    emit(8'h31); emit(8'hFE); emit(8'hFF);
    m_sp = 16'hFFFE; m_pc += 3; push("R8", 0, 0, 0);
    // R7: absolute accumulator load and store
    mem[16'h2000] = 8'h5A;
    emit(8'h3A); emit(8'h00); emit(8'h20);
    m_a = 8'h5A; m_pc += 3; push("R7", 0, 0, 0);
    emit(8'h32); emit(8'h01); emit(8'h20);
    m_pc += 3; push("R7", 1, 16'h2001, m_a);
    // R3 through IX, R5 through IY (base 0x0010, negative displacement wraps)
    for (int ri = 0; ri < 7; ri++) begin
      int r;
      logic [7:0] d;
      r = (ri == 6) ? 7 : ri;
      d = 8'h10 + 8'(ri);
      emit(8'hDD); emit(8'h70 | 8'(r)); emit(d);
      m_pc += 3; push("R3", 1, m_ix + sext(d), get_r(r));
      d = 8'h80 + 8'(ri);
      emit(8'hFD); emit(8'h70 | 8'(r)); emit(d);
      m_pc += 3; push("R5", 1, m_iy + sext(d), get_r(r));
    end
    // R4 through IX (negative displacement), R2 through IY
    for (int ri = 0; ri < 7; ri++) begin
      int r;
      logic [7:0] d;
      logic [7:0] v;
      r = (ri == 6) ? 7 : ri;
      d = 8'hF0 + 8'(ri);
      v = 8'hC0 + 8'(ri * 7);
      mem[m_ix + sext(d)] = v;
      emit(8'hDD); emit(8'h46 | 8'(r << 3)); emit(d);
      set_r(r, v); m_pc += 3; push("R4", 0, 0, 0);
      d = 8'h90 + 8'(ri);
      v = 8'h31 + 8'(ri * 11);
      mem[m_iy + sext(d)] = v;
      emit(8'hFD); emit(8'h46 | 8'(r << 3)); emit(d);
      set_r(r, v); m_pc += 3; push("R2", 0, 0, 0);
    end
    // R6: immediate byte through IX and IY
    emit(8'hDD); emit(8'h36); emit(8'h05); emit(8'hA7);
    m_pc += 4; push("R6", 1, m_ix + 16'h0005, 8'hA7);
    emit(8'hFD); emit(8'h36); emit(8'h7F); emit(8'h3C);
    m_pc += 4; push("R6", 1, m_iy + 16'h007F, 8'h3C);
    // R10: unsupported prefixed opcode
    ill_pc = m_pc;
    emit(8'hDD); emit(8'h01);
  endtask

  initial begin
    logic [15:0] ill_pc;
    bit finished;
    build_program(ill_pc);
    repeat (3) @(negedge clk_i);
    check("R1", "pc in reset", 128'(pc_o), 128'(0));
    check("R1", "regs in reset", 128'(dut_st()), 128'(0));
    check("R1", "flags in reset", 128'({done_o, illegal_o}), 128'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "done/illegal after reset", 128'({done_o, illegal_o}), 128'(0));
    finished = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && illegal_o) begin
        finished = 1;
        break;
      end
    end
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d pending", exp_q.size(), 0);
    end
    repeat (10) @(negedge clk_i);
    check("R10", "illegal held", 128'(illegal_o), 128'(1));
    check("R10", "pc frozen at bad opcode", 128'(pc_o), 128'(ill_pc));
    check("R10", "registers untouched", 128'(dut_st()), 128'(model_st()));
    check("R10", "no retire after illegal", 128'(exp_q.size()), 128'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule